// File: doc/BRIEF.md
# Shared-Vector Interrupt Source Selector

This block is the front end between a set of interrupt sources and four interrupt request lines, each of which serves a vector shared by two sources. An 8-bit configuration register on a byte-wide write port with a combinational read-back chooses which source of each pair drives its line. It also sets, for each of three external interrupt pins, whether one edge or both edges raise a request.

Each external pin is brought into the clock domain by a two-flop synchronizer and then compared against its previous sample. A detected edge becomes a request one clock wide on the line the pin shares. Internal events are one-cycle pulses and pass straight through when selected. Events from the source that is not selected are dropped. The fourth line pairs a CAN error event with a key-input event. The key-input event can only be chosen while the sharing-enable input is high. The priority controller, vector fetch, per-source control registers and pin pull-ups are outside this block.

Top module: `irq_cause_steer`

## Requirements
- R1: After reset, configuration bits 6..0 are 0. A write stores bits 6..0 and read-back returns them. Bit 7 has no storage and always reads 0, whatever value was written to it.
- R2: Line irq_req[0] carries timer0_evt while config bit 0 is 0, and the request from ext_irq[1] while bit 0 is 1.
- R3: Line irq_req[1] carries timer1_evt while config bit 1 is 0, and the request from ext_irq[0] while bit 1 is 1.
- R4: Line irq_req[2] carries timer2_evt while config bit 2 is 0, and the request from ext_irq[2] while bit 2 is 1.
- R5: Line irq_req[3] carries key_evt only when share_en is 1 and config bit 6 is 1. In every other case it carries can_err_evt.
- R6: With a pin's edge-mode bit at 0, pin_pol 0 makes only falling edges raise a request, and pin_pol 1 makes only rising edges raise a request.
- R7: Config bits 3, 4 and 5 put ext_irq[0], ext_irq[1] and ext_irq[2] respectively into both-edge mode, where rising and falling edges both raise a request.
- R8: A pin change applied before clock edge k shows as a request in the cycle after edge k+1. The request lasts exactly one cycle.
- R9: An event from the unselected source of a pair never appears on that pair's line.
- R10: While a write that changes a pin's select bit or edge-mode bit is presented, that pin raises no request, and any edge pending in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| reg_wr | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Configuration read-back, bit 7 reads 0 |
| ext_irq | input | 3 | Asynchronous external interrupt pins |
| pin_pol | input | 3 | Per-pin active edge in single-edge mode: 0 falling, 1 rising |
| share_en | input | 1 | Allows config bit 6 to select key_evt for line 3 |
| timer0_evt | input | 1 | Internal event paired with ext_irq[1] |
| timer1_evt | input | 1 | Internal event paired with ext_irq[0] |
| timer2_evt | input | 1 | Internal event paired with ext_irq[2] |
| can_err_evt | input | 1 | CAN error event for line 3 |
| key_evt | input | 1 | Key-input event for line 3 |
| irq_req | output | 4 | Interrupt request lines to the priority controller |

## Verification
The assertions check on every cycle that writes read back, that bit 7 stays 0, and that internal events pass through when their source is selected. They also check that line 3 follows the CAN error event whenever sharing is off, and that a single-edge pin request never lasts two cycles. Only the bench scenarios can show the two-edge latency through the synchronizer, the choice between falling and rising edge, both-edge detection on each pin, and the mapping of pins to lines. The same holds for discarding an edge that coincides with a mode-changing write.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int CFG_W     = 8;
  localparam int NUM_PINS  = 3;
  localparam int NUM_LINES = 4;
  localparam int SHARE_LINE = NUM_LINES - 1;

  // Configuration byte layout, MSB first.
  typedef struct packed {
    logic                rsvd;       // bit 7, no storage
    logic                sel_key;    // bit 6, line 3 source
    logic [NUM_PINS-1:0] both_edge;  // bits 5..3, per pin
    logic [2:0]          sel_pin;    // bits 2..0, per line
  } cause_cfg_t;

  // Line that each external pin shares.
  function automatic int pin_line(input int p);
    case (p)
      0:       return 1;
      1:       return 0;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_steer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_W-1:0]    wr_data,
  output cause_cfg_t          cfg,
  output logic [CFG_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] rearm
);

  cause_cfg_t cfg_q;
  cause_cfg_t cfg_d;

  always_comb begin
    cfg_d      = cause_cfg_t'(wr_data);
    cfg_d.rsvd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // A write that flips a pin's select or edge mode re-arms that pin.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_rearm
    localparam int LINE = pin_line(p);
    assign rearm[p] = wr_en &&
                      ((cfg_d.both_edge[p] != cfg_q.both_edge[p]) ||
                       (cfg_d.sel_pin[LINE] != cfg_q.sel_pin[LINE]));
  end

  assign cfg     = cfg_q;
  assign rd_data = CFG_W'(cfg_q);

endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic pol_rise,
  input  logic both_edge,
  input  logic rearm,
  output logic hit
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;
  logic         prev_q;
  logic         prev_d;
  logic         sampled;
  logic         rise;
  logic         fall;
  logic         edge_hit;

  assign sampled = sync_q[TOP];

  always_comb begin
    sync_d = {sync_q[TOP-1:0], pin_in};
    prev_d = sampled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = sampled & ~prev_q;
    fall = ~sampled & prev_q;
    if (both_edge) begin
      edge_hit = rise | fall;
    end else if (pol_rise) begin
      edge_hit = rise;
    end else begin
      edge_hit = fall;
    end
    hit = edge_hit & ~rearm;
  end

endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer #(
  parameter int LINES = 4
) (
  input  logic [LINES-1:0] base_evt,
  input  logic [LINES-1:0] alt_evt,
  input  logic [LINES-1:0] sel_alt,
  output logic [LINES-1:0] req
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign req[i] = sel_alt[i] ? alt_evt[i] : base_evt[i];
  end

endmodule

// File: rtl/irq_cause_steer.sv
module irq_cause_steer
  import irq_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [CFG_W-1:0]     reg_wdata,
  output logic [CFG_W-1:0]     reg_rdata,
  input  logic [NUM_PINS-1:0]  ext_irq,
  input  logic [NUM_PINS-1:0]  pin_pol,
  input  logic                 share_en,
  input  logic                 timer0_evt,
  input  logic                 timer1_evt,
  input  logic                 timer2_evt,
  input  logic                 can_err_evt,
  input  logic                 key_evt,
  output logic [NUM_LINES-1:0] irq_req
);

  cause_cfg_t           cfg;
  logic [NUM_PINS-1:0]  rearm;
  logic [NUM_PINS-1:0]  pin_hit;
  logic [NUM_LINES-1:0] base_evt;
  logic [NUM_LINES-1:0] alt_evt;
  logic [NUM_LINES-1:0] sel_alt;

  irq_cause_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .cfg     (cfg),
    .rd_data (reg_rdata),
    .rearm   (rearm)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int LINE = pin_line(p);
    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (ext_irq[p]),
      .pol_rise  (pin_pol[p]),
      .both_edge (cfg.both_edge[p]),
      .rearm     (rearm[p]),
      .hit       (pin_hit[p])
    );
    assign alt_evt[LINE] = pin_hit[p];
  end

  assign alt_evt[SHARE_LINE] = key_evt;
  assign base_evt = {can_err_evt, timer2_evt, timer1_evt, timer0_evt};
  assign sel_alt  = {share_en & cfg.sel_key, cfg.sel_pin};

  irq_line_steer #(.LINES(NUM_LINES)) u_steer (
    .base_evt (base_evt),
    .alt_evt  (alt_evt),
    .sel_alt  (sel_alt),
    .req      (irq_req)
  );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       share_en,
  input logic       timer0_evt,
  input logic       can_err_evt,
  input logic [3:0] irq_req
);

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[6:0] == $past(reg_wdata[6:0])); // R1

  AST_NO_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7]); // R1

  AST_TIMER0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] |-> irq_req[0] == timer0_evt); // R2

  AST_SHARE_OFF_CAN: assert property (@(posedge clk) disable iff (!rst_n)
    !share_en |-> irq_req[3] == can_err_evt); // R5

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !reg_rdata[4] && irq_req[0] && !reg_wr)
      |=> (!irq_req[0] || !reg_rdata[0])); // R8

endmodule

bind irq_cause_steer irq_steer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .share_en    (share_en),
  .timer0_evt  (timer0_evt),
  .can_err_evt (can_err_evt),
  .irq_req     (irq_req)
);

// File: tb/irq_cause_steer_test.sv
`timescale 1ns/1ps
module irq_cause_steer_test;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [2:0] ext_irq;
  logic [2:0] pin_pol;
  logic       share_en;
  logic       timer0_evt;
  logic       timer1_evt;
  logic       timer2_evt;
  logic       can_err_evt;
  logic       key_evt;
  logic [3:0] irq_req;

  int n_chk;
  int n_fail;
  bit done;

  irq_cause_steer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ext_irq     (ext_irq),
    .pin_pol     (pin_pol),
    .share_en    (share_en),
    .timer0_evt  (timer0_evt),
    .timer1_evt  (timer1_evt),
    .timer2_evt  (timer2_evt),
    .can_err_evt (can_err_evt),
    .key_evt     (key_evt),
    .irq_req     (irq_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row: {cfg[7:0], share_en, events {key,can,t2,t1,t0}, expected irq_req[3:0]}
  localparam int ROWS = 10;
  localparam logic [17:0] VEC [ROWS] = '{
    {8'h00, 1'b0, 5'b00001, 4'b0001},
    {8'h00, 1'b0, 5'b01111, 4'b1111},
    {8'h07, 1'b0, 5'b01111, 4'b1000},  // R9 timers unselected
    {8'h40, 1'b0, 5'b11000, 4'b1000},
    {8'h40, 1'b0, 5'b10000, 4'b0000},  // R9 key dropped
    {8'h40, 1'b1, 5'b10000, 4'b1000},
    {8'h40, 1'b1, 5'b01000, 4'b0000},  // R9 can dropped
    {8'h00, 1'b1, 5'b11000, 4'b1000},
    {8'h02, 1'b0, 5'b00110, 4'b0100},
    {8'h05, 1'b0, 5'b00111, 4'b0010}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Change a pin, then expect the request in the cycle after the second edge
  // and no request one cycle later.
  task automatic pin_step(input int idx, input logic val, input int line,
                          input logic exp, input string tag);
    @(negedge clk);
    ext_irq[idx] = val;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {7'd0, irq_req[line]}, {7'd0, exp});
    @(negedge clk);
    chk({tag, " R8 width"}, {7'd0, irq_req[line]}, 8'd0);
    settle();
  endtask

  function automatic string line_tag(input int l);
    case (l)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
    ext_irq = 3'b000;
    pin_pol = 3'b000;
    share_en = 1'b0;
    {key_evt, can_err_evt, timer2_evt, timer1_evt, timer0_evt} = 5'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and storage
    chk("R1 reset", reg_rdata, 8'h00);
    chk("R1 reset irq", {4'd0, irq_req}, 8'h00);
    write_cfg(8'hFF);
    chk("R1 bit7 ignored", reg_rdata, 8'h7F);
    write_cfg(8'h2A);
    chk("R1 readback", reg_rdata, 8'h2A);

    // Table of internal-event steering
    for (int r = 0; r < ROWS; r++) begin
      write_cfg(VEC[r][17:10]);
      @(negedge clk);
      share_en = VEC[r][9];
      {key_evt, can_err_evt, timer2_evt, timer1_evt, timer0_evt} = VEC[r][8:4];
      #1;
      for (int l = 0; l < 4; l++) begin
        chk($sformatf("%s row %0d line %0d", line_tag(l), r, l),
            {7'd0, irq_req[l]}, {7'd0, VEC[r][l]});
      end
      @(negedge clk);
      {key_evt, can_err_evt, timer2_evt, timer1_evt, timer0_evt} = 5'b0;
      share_en = 1'b0;
    end

    // R6 single edge, falling (pol 0) on ext_irq[1] via line 0
    write_cfg(8'h01);
    settle();
    pin_step(1, 1'b1, 0, 1'b0, "R6 rise ignored");
    pin_step(1, 1'b0, 0, 1'b1, "R6 fall");
    // R6 rising
    pin_pol[1] = 1'b1;
    pin_step(1, 1'b1, 0, 1'b1, "R6 rise");
    pin_step(1, 1'b0, 0, 1'b0, "R6 fall ignored");
    pin_pol[1] = 1'b0;

    // R7 both edges on ext_irq[0] via line 1 (bit 1 select, bit 3 mode)
    write_cfg(8'h0A);
    settle();
    pin_step(0, 1'b1, 1, 1'b1, "R7 pin0 rise");
    pin_step(0, 1'b0, 1, 1'b1, "R7 pin0 fall");
    // R7 both edges on ext_irq[2] via line 2 (bit 2 select, bit 5 mode)
    write_cfg(8'h24);
    settle();
    pin_step(2, 1'b1, 2, 1'b1, "R7 pin2 rise");
    pin_step(2, 1'b0, 2, 1'b1, "R7 pin2 fall");
    // R7 both edges on ext_irq[1] via line 0 (bit 0 select, bit 4 mode)
    write_cfg(8'h11);
    settle();
    pin_step(1, 1'b1, 0, 1'b1, "R7 pin1 rise");
    pin_step(1, 1'b0, 0, 1'b1, "R7 pin1 fall");

    // R9 pin edge with timer selected does not reach the line
    write_cfg(8'h10);
    settle();
    pin_step(1, 1'b1, 0, 1'b0, "R9 pin unselected");
    pin_step(1, 1'b0, 0, 1'b0, "R9 pin unselected fall");

    // R10 mode-changing write coincides with a pending falling edge
    write_cfg(8'h01);
    ext_irq[1] = 1'b1;
    settle();
    @(negedge clk);
    ext_irq[1] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = 8'h11;
    #0.5;
    chk("R10 suppressed", {7'd0, irq_req[0]}, 8'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    #0.5;
    chk("R10 discarded", {7'd0, irq_req[0]}, 8'd0);
    settle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule